// File: doc/BRIEF.md
# Data Access Permission Checker

This block sits behind a translation lookup that has already hit. For each data access it takes the access kind, the privilege of the running code, whether the access was issued with no-fault semantics, and the attribute bits of the matching page entry. From these it decides whether the access may proceed. A refused access gets a single fault code that names the most urgent reason. A permitted access may be flagged as uncacheable with strict ordering. When any fault is raised, the block also captures the faulting virtual page number and context into a tag-access register, which a trap handler can read afterwards.

Every result is registered, and each request strobe produces one response cycle. Address-space decoding, the translation lookup and trap delivery all take place outside this block.

Top module: `dperm_checker`

## Requirements
- R1: A request with `req_priv`=0 to a page with `pg_priv`=1 yields fault code 1 (privilege violation). This check outranks every other check.
- R2: When R1 does not fire, a write (`req_write`=1) to a page with `pg_writable`=0 yields fault code 2 (protection).
- R3: When R1 and R2 do not fire, an access with `req_nofault`=0 to a page with `pg_nfo`=1 yields fault code 3 (no-fault-only violation).
- R4: When R1 to R3 do not fire, an access with `req_nofault`=1 to a page with `pg_side`=1 yields fault code 4 (side effect).
- R5: A response reports only the highest-priority fault. `rsp_permit` is 1 exactly when the code is 0, so no rule fired.
- R6: `rsp_uncache` is 1 when the access is permitted and either `pg_side`=1 or physical address bit 39 (`pg_paddr[39]`) is 1. A refused access never has `rsp_uncache` set.
- R7: On a faulting response, `rsp_capture` pulses for that one cycle. In the same cycle `tag_access` becomes {virtual page number, context}: the 51-bit page number in bits 63:13 and the 13-bit context in bits 12:0.
- R8: A permitted request and an idle cycle both leave `tag_access` unchanged.
- R9: Every response appears in the cycle after the request strobe. Without a strobe, `rsp_valid`, `rsp_permit`, `rsp_fault`, `rsp_uncache` and `rsp_capture` are all 0.
- R10: During reset, every output, `tag_access` included, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Issuing code is privileged |
| req_nofault | input | 1 | Access issued with no-fault semantics |
| pg_priv | input | 1 | Page requires privilege |
| pg_writable | input | 1 | Page may be written |
| pg_nfo | input | 1 | Page accepts only no-fault accesses |
| pg_side | input | 1 | Page has side effects |
| pg_paddr | input | 40 | Translated physical address |
| req_vpn | input | 51 | Virtual address bits 63:13 |
| req_ctx | input | 13 | Context of the access |
| rsp_valid | output | 1 | Response strobe |
| rsp_permit | output | 1 | Access may proceed |
| rsp_fault | output | 3 | Fault code: 0 none, 1 privilege, 2 protection, 3 no-fault-only, 4 side effect |
| rsp_uncache | output | 1 | Uncacheable, strictly ordered access |
| rsp_capture | output | 1 | Tag-access register loaded this cycle |
| tag_access | output | 64 | Captured page number and context |

## Verification
A request is driven on a falling edge and registered on the next rising edge. Its permit flag, fault code, uncache flag and capture strobe are therefore due one cycle later, and so is the `tag_access` update, which lands on that same edge. The bench samples each result on the falling edge that follows that rising edge. It then drives the next request on the same falling edge, so back-to-back strobes are covered. In idle cycles the bench checks that all flags drop and that the captured tag keeps the value from the last fault.

// File: rtl/dperm_pkg.sv
package dperm_pkg;

  // Fault codes; numeric order equals check priority (lower code wins).
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_PRIV = 3'd1,
    FLT_PROT = 3'd2,
    FLT_NFO  = 3'd3,
    FLT_SIDE = 3'd4
  } fault_e;

  localparam int NUM_RULES = 4;

  // Rule vector: index i maps to fault code i+1.
  function automatic logic [NUM_RULES-1:0] rule_hits(
    input logic wr, input logic priv_lvl, input logic nf_acc,
    input logic p_priv, input logic p_wr, input logic p_nfo, input logic p_side);
    logic [NUM_RULES-1:0] h;
    h[0] = !priv_lvl && p_priv;
    h[1] = wr && !p_wr;
    h[2] = p_nfo && !nf_acc;
    h[3] = p_side && nf_acc;
    return h;
  endfunction

endpackage

// File: rtl/dperm_fault_eval.sv
module dperm_fault_eval
  import dperm_pkg::*;
(
  input  logic                 acc_write,
  input  logic                 acc_priv,
  input  logic                 acc_nofault,
  input  logic                 page_priv,
  input  logic                 page_writable,
  input  logic                 page_nfo,
  input  logic                 page_side,
  output logic [NUM_RULES-1:0] rule_hit,
  output fault_e               fault_code,
  output logic                 any_fault
);

  assign rule_hit = rule_hits(acc_write, acc_priv, acc_nofault,
                              page_priv, page_writable, page_nfo, page_side);

  // Scan from lowest priority to highest so the highest firing rule stays.
  always_comb begin
    fault_code = FLT_NONE;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (rule_hit[i]) fault_code = fault_e'(3'(i + 1));
    end
  end

  assign any_fault = |rule_hit;

endmodule

// File: rtl/dperm_cache_attr.sv
module dperm_cache_attr #(
  parameter int PA_W   = 40,
  parameter int UC_BIT = 39
) (
  input  logic [PA_W-1:0] paddr,
  input  logic            side_effect,
  output logic            uncache_raw
);

  localparam logic [PA_W-1:0] UC_MASK = PA_W'(1) << UC_BIT;

  assign uncache_raw = side_effect || (|(paddr & UC_MASK));

endmodule

// File: rtl/dperm_tag_reg.sv
module dperm_tag_reg #(
  parameter int VA_W       = 64,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [VA_W-PAGE_SHIFT-1:0] vpn,
  input  logic [CTX_W-1:0]           ctx,
  output logic [VA_W-1:0]            tag_q
);

  logic [PAGE_SHIFT-1:0] ctx_field;

  generate
    if (CTX_W >= PAGE_SHIFT) begin : g_ctx_trim
      logic [CTX_W-1:0] ctx_all;
      assign ctx_all   = ctx;
      assign ctx_field = ctx_all[PAGE_SHIFT-1:0];
    end else begin : g_ctx_pad
      assign ctx_field = {{(PAGE_SHIFT-CTX_W){1'b0}}, ctx};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      tag_q <= '0;
    else if (cap_en) tag_q <= {vpn, ctx_field};
  end

endmodule

// File: rtl/dperm_checker.sv
module dperm_checker
  import dperm_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 40,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int UC_BIT     = 39
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_priv,
  input  logic                       req_nofault,
  input  logic                       pg_priv,
  input  logic                       pg_writable,
  input  logic                       pg_nfo,
  input  logic                       pg_side,
  input  logic [PA_W-1:0]            pg_paddr,
  input  logic [VA_W-PAGE_SHIFT-1:0] req_vpn,
  input  logic [CTX_W-1:0]           req_ctx,
  output logic                       rsp_valid,
  output logic                       rsp_permit,
  output logic [2:0]                 rsp_fault,
  output logic                       rsp_uncache,
  output logic                       rsp_capture,
  output logic [VA_W-1:0]            tag_access
);

  // Named internal events
  logic [NUM_RULES-1:0] ev_rule_hit;
  fault_e               ev_fault;
  logic                 ev_any_fault;
  logic                 ev_uncache_raw;
  logic                 ev_capture;

  dperm_fault_eval u_eval (
    .acc_write     (req_write),
    .acc_priv      (req_priv),
    .acc_nofault   (req_nofault),
    .page_priv     (pg_priv),
    .page_writable (pg_writable),
    .page_nfo      (pg_nfo),
    .page_side     (pg_side),
    .rule_hit      (ev_rule_hit),
    .fault_code    (ev_fault),
    .any_fault     (ev_any_fault)
  );

  dperm_cache_attr #(.PA_W(PA_W), .UC_BIT(UC_BIT)) u_cattr (
    .paddr       (pg_paddr),
    .side_effect (pg_side),
    .uncache_raw (ev_uncache_raw)
  );

  assign ev_capture = req_valid && ev_any_fault;

  dperm_tag_reg #(.VA_W(VA_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT)) u_tag (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (ev_capture),
    .vpn    (req_vpn),
    .ctx    (req_ctx),
    .tag_q  (tag_access)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_permit  <= 1'b0;
      rsp_fault   <= FLT_NONE;
      rsp_uncache <= 1'b0;
      rsp_capture <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_permit  <= req_valid && !ev_any_fault;
      rsp_fault   <= req_valid ? ev_fault : FLT_NONE;
      rsp_uncache <= req_valid && !ev_any_fault && ev_uncache_raw;
      rsp_capture <= ev_capture;
    end
  end

endmodule

// File: rtl/dperm_checker_sva.sv
module dperm_checker_sva #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 40,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int UC_BIT     = 39
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic                       req_priv,
  input logic                       req_nofault,
  input logic                       pg_priv,
  input logic                       pg_writable,
  input logic                       pg_nfo,
  input logic                       pg_side,
  input logic [VA_W-PAGE_SHIFT-1:0] req_vpn,
  input logic [CTX_W-1:0]           req_ctx,
  input logic                       rsp_valid,
  input logic                       rsp_permit,
  input logic [2:0]                 rsp_fault,
  input logic                       rsp_uncache,
  input logic                       rsp_capture,
  input logic [VA_W-1:0]            tag_access,
  input logic                       ev_capture
);

  AST_PRIV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && pg_priv) |=> (rsp_fault == 3'd1)); // R1

  AST_WRITE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv || !pg_priv) && req_write && !pg_writable)
      |=> (rsp_fault == 3'd2)); // R2

  AST_NFO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv || !pg_priv) && (!req_write || pg_writable)
      && pg_nfo && !req_nofault) |=> (rsp_fault == 3'd3)); // R3

  AST_SIDE_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv || !pg_priv) && (!req_write || pg_writable)
      && pg_side && req_nofault) |=> (rsp_fault == 3'd4)); // R4

  AST_PERMIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_permit == (rsp_fault == 3'd0))); // R5

  AST_UNCACHE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncache |-> rsp_permit); // R6

  AST_CAPTURE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> (rsp_capture && tag_access[VA_W-1:PAGE_SHIFT] == $past(req_vpn))); // R7

  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_capture |=> $stable(tag_access)); // R8

  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_permit && rsp_fault == 3'd0 && !rsp_uncache && !rsp_capture)); // R9

  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault <= 3'd4); // R5

  AST_CTX_UNUSED_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_capture) |-> $past(req_valid)); // R7

  // Keep the context input referenced for width checking of the bind.
  logic ctx_seen;
  assign ctx_seen = |req_ctx;

endmodule

bind dperm_checker dperm_checker_sva #(
  .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT), .UC_BIT(UC_BIT)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_priv    (req_priv),
  .req_nofault (req_nofault),
  .pg_priv     (pg_priv),
  .pg_writable (pg_writable),
  .pg_nfo      (pg_nfo),
  .pg_side     (pg_side),
  .req_vpn     (req_vpn),
  .req_ctx     (req_ctx),
  .rsp_valid   (rsp_valid),
  .rsp_permit  (rsp_permit),
  .rsp_fault   (rsp_fault),
  .rsp_uncache (rsp_uncache),
  .rsp_capture (rsp_capture),
  .tag_access  (tag_access),
  .ev_capture  (ev_capture)
);

// File: tb/test_dperm_checker.sv
module test_dperm_checker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv, req_nofault;
  logic        pg_priv, pg_writable, pg_nfo, pg_side;
  logic [39:0] pg_paddr;
  logic [50:0] req_vpn;
  logic [12:0] req_ctx;
  logic        rsp_valid, rsp_permit, rsp_uncache, rsp_capture;
  logic [2:0]  rsp_fault;
  logic [63:0] tag_access;

  int checks = 0;
  int errors = 0;
  logic [63:0] model_tag;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  dperm_checker i_dperm_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_nofault(req_nofault), .pg_priv(pg_priv),
    .pg_writable(pg_writable), .pg_nfo(pg_nfo), .pg_side(pg_side),
    .pg_paddr(pg_paddr), .req_vpn(req_vpn), .req_ctx(req_ctx),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_fault(rsp_fault),
    .rsp_uncache(rsp_uncache), .rsp_capture(rsp_capture), .tag_access(tag_access)
  );

  // Expected fault from the requirement text, written as an if-chain.
  function automatic logic [2:0] want_fault(input logic w, input logic p, input logic nf,
      input logic pp, input logic pw, input logic pn, input logic ps);
    if (!p && pp)      return 3'd1; // R1
    else if (w && !pw) return 3'd2; // R2
    else if (pn && !nf) return 3'd3; // R3
    else if (ps && nf) return 3'd4; // R4
    else               return 3'd0;
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Drive one request on a falling edge, check at the next falling edge.
  task automatic access(input logic w, input logic p, input logic nf,
      input logic pp, input logic pw, input logic pn, input logic ps,
      input logic [39:0] pa, input logic [50:0] vpn, input logic [12:0] ctx);
    logic [2:0] ef;
    logic       eu;
    ef = want_fault(w, p, nf, pp, pw, pn, ps);
    eu = (ef == 3'd0) && (ps || pa[39]);
    req_valid = 1'b1; req_write = w; req_priv = p; req_nofault = nf;
    pg_priv = pp; pg_writable = pw; pg_nfo = pn; pg_side = ps;
    pg_paddr = pa; req_vpn = vpn; req_ctx = ctx;
    if (ef != 3'd0) model_tag = {vpn, ctx};
    @(negedge clk);
    chk("R9", "valid", 64'(rsp_valid), 64'd1);
    chk(ef == 3'd1 ? "R1" : ef == 3'd2 ? "R2" : ef == 3'd3 ? "R3" : ef == 3'd4 ? "R4" : "R5",
        "fault", 64'(rsp_fault), 64'(ef));
    chk("R5", "permit", 64'(rsp_permit), 64'(ef == 3'd0));
    chk("R6", "uncache", 64'(rsp_uncache), 64'(eu));
    chk("R7", "capture", 64'(rsp_capture), 64'(ef != 3'd0));
    chk(ef != 3'd0 ? "R7" : "R8", "tag", tag_access, model_tag);
  endtask

  task automatic idle_cycle();
    req_valid = 1'b0;
    req_vpn = 51'h7_ABCD_1234_5678; req_ctx = 13'h1FFF;
    pg_priv = 1'b1; req_priv = 1'b0;
    @(negedge clk);
    chk("R9", "idle valid", 64'(rsp_valid), 64'd0);
    chk("R9", "idle flags", {59'd0, rsp_permit, rsp_uncache, rsp_capture, rsp_fault != 3'd0, 1'b0}, 64'd0);
    chk("R8", "idle tag", tag_access, model_tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; req_valid = 1'b1; req_write = 1'b1; req_priv = 1'b0; req_nofault = 1'b0;
    pg_priv = 1'b1; pg_writable = 1'b0; pg_nfo = 1'b1; pg_side = 1'b1;
    pg_paddr = '1; req_vpn = '1; req_ctx = '1;
    model_tag = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset flags", {58'd0, rsp_valid, rsp_permit, rsp_uncache, rsp_capture, rsp_fault != 3'd0, 1'b0}, 64'd0);
    chk("R10", "reset tag", tag_access, 64'd0);
    rst_n = 1'b1;
    idle_cycle();

    // Directed corner cases
    access(0, 1, 0, 0, 1, 0, 0, 40'h00_1234_5000, 51'h1, 13'h1);            // clean read
    access(1, 0, 0, 1, 0, 1, 0, 40'h00_0000_0000, 51'h2A, 13'h15);          // R1 beats R2,R3
    access(1, 0, 1, 1, 0, 0, 1, 40'h80_0000_0000, 51'h3B, 13'h0);           // R1 beats R2,R4
    access(1, 1, 0, 1, 0, 1, 0, 40'h00_0000_0000, 51'h4C, 13'h2);           // R2 beats R3
    access(1, 0, 1, 0, 0, 0, 1, 40'h00_0000_0000, 51'h5D, 13'h3);           // R2 beats R4
    access(0, 0, 0, 0, 1, 1, 0, 40'h00_0000_0000, 51'h6E, 13'h4);           // R3
    access(0, 1, 1, 0, 0, 1, 1, 40'h00_0000_0000, 51'h7F, 13'h5);           // nfo ok, R4
    access(0, 1, 0, 0, 0, 0, 1, 40'h00_0000_0000, 51'h11, 13'h6);           // R6 side only
    access(1, 1, 0, 0, 1, 0, 0, 40'h80_0000_0000, 51'h12, 13'h7);           // R6 pa bit 39
    access(1, 1, 0, 0, 1, 0, 0, 40'h7F_FFFF_FFFF, 51'h13, 13'h8);           // R6 other bits
    access(0, 0, 0, 0, 0, 1, 1, 40'h80_0000_0000, 51'h7_FFFF_FFFF_FFFF, 13'h1FFF); // R3, no uncache
    idle_cycle();
    idle_cycle();

    // Random traffic with occasional idle gaps
    for (int n = 0; n < 600; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if (r[7:5] == 3'd0) idle_cycle();
      else access(r[0], r[1], r[2], r[3], r[4], r[5], r[6],
                  {8'($urandom), 32'($urandom)},
                  {19'($urandom), 32'($urandom)}, 13'($urandom));
    end
    idle_cycle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule